// File: doc/BRIEF.md
# Dual Address Generation Unit

This block produces two data-memory addresses in every clock cycle: one for the X memory space and one for the Y memory space. Each space has its own arithmetic path and its own bank of pointer, offset and modifier registers. An instruction decoder outside the block drives, for each space, an enable, a register select and an addressing mode.

The block presents the current pointer as the effective address. At the clock edge it stores the post-modified pointer back. The modifier register chosen with the pointer sets the arithmetic. A modifier of all ones gives plain linear arithmetic that wraps at the top of the address space. Any other value M gives a circular buffer of M+1 words. Its base is the pointer with the low bits cleared, down to the smallest power of two that is at least M+1.

A separate register port lets software-style code use every register as plain data. The write side and the read side are independent. The read side is combinational.

Top module: `dual_agu`

## Requirements
- R1: After reset every pointer and every offset register reads 0, and every modifier register reads all ones (1023 at the default 10-bit width).
- R2: In each cycle, x_addr shows the pointer chosen by x_sel in the X bank, and y_addr shows the pointer chosen by y_sel in the Y bank. Each output shows the pointer value from before any update in that cycle. The two units work in the same cycle without affecting each other. Pointers 0-3 form the X bank and pointers 4-7 form the Y bank.
- R3: The mode codes are: 0 = access with no update, 1 = post-increment by one, 2 = post-decrement by one, 3 = post-add the offset register of the same number, 4 = post-subtract that offset register. Codes 5-7 and a low enable leave the pointer unchanged.
- R4: When the modifier is all ones, updates use linear arithmetic modulo 1024. For example, 0 minus 1 gives 1023, and 1023 plus 1 gives 0.
- R5: When the modifier M is not all ones, an increment or decrement stays inside the buffer [base, base+M]. Passing the upper end wraps to the base, and passing below the base wraps to base+M.
- R6: Offset updates (mode 3 and mode 4) with a modifier M follow the same circular rule as R5, for offsets smaller than M+1. A result above base+M has M+1 subtracted. A result below the base has M+1 added.
- R7: A modifier of 0 makes a one-word buffer, so every update leaves the pointer unchanged.
- R8: The register port selects a register with a bank code and a number 0-7. The bank codes are 0 = pointer, 1 = offset, 2 = modifier. A write stores rf_wdata at the clock edge. The read returns the selected register in the same cycle. A write with bank code 3 changes nothing, and a read with bank code 3 returns 0.
- R9: If a register-port write and a post-update target the same pointer in one cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_en | input | 1 | X unit access enable |
| x_sel | input | 2 | X pointer select within the X bank |
| x_mode | input | 3 | X addressing mode |
| y_en | input | 1 | Y unit access enable |
| y_sel | input | 2 | Y pointer select within the Y bank |
| y_mode | input | 3 | Y addressing mode |
| x_addr | output | 10 | X effective address |
| y_addr | output | 10 | Y effective address |
| rf_we | input | 1 | Register port write enable |
| rf_wbank | input | 2 | Write bank code |
| rf_wnum | input | 3 | Write register number |
| rf_wdata | input | 10 | Write data |
| rf_rbank | input | 2 | Read bank code |
| rf_rnum | input | 3 | Read register number |
| rf_rdata | output | 10 | Read data |

## Verification
The bench walks pointers across both ends of a non-power-of-two buffer (size 10 at base 32) with unit steps and offset steps. A design that compares against the wrong bound would leave the buffer or wrap one word early. Linear wrap through 0 and 1023 in the Y bank catches a design that applies buffer logic to an all-ones modifier. A one-word buffer exposes an off-by-one in the wrap arithmetic, because any such error moves the pointer. A register write that collides with a post-increment, together with the unused mode codes and the unused bank code, shows whether a design lets an update win the collision, or lets an undefined code alter state.

// File: rtl/dual_agu.sv
module dual_agu #(
  parameter int AW  = 10,
  parameter int PER = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        x_en,
  input  logic [$clog2(PER)-1:0]      x_sel,
  input  logic [2:0]                  x_mode,
  input  logic                        y_en,
  input  logic [$clog2(PER)-1:0]      y_sel,
  input  logic [2:0]                  y_mode,
  output logic [AW-1:0]               x_addr,
  output logic [AW-1:0]               y_addr,
  input  logic                        rf_we,
  input  logic [1:0]                  rf_wbank,
  input  logic [$clog2(2*PER)-1:0]    rf_wnum,
  input  logic [AW-1:0]               rf_wdata,
  input  logic [1:0]                  rf_rbank,
  input  logic [$clog2(2*PER)-1:0]    rf_rnum,
  output logic [AW-1:0]               rf_rdata
);
  localparam int NREG = 2 * PER;
  localparam int SW   = $clog2(PER);
  localparam int IW   = $clog2(NREG);

  logic [NREG-1:0][AW-1:0] r_q, n_q, m_q;

  logic [1:0]         u_en, u_upd;
  logic [1:0][SW-1:0] u_sel;
  logic [1:0][2:0]    u_mode;
  logic [1:0][AW-1:0] u_addr, u_next;

  assign u_en   = {y_en, x_en};
  assign u_sel  = {y_sel, x_sel};
  assign u_mode = {y_mode, x_mode};
  assign x_addr = u_addr[0];
  assign y_addr = u_addr[1];

  for (genvar g = 0; g < 2; g++) begin : g_unit
    logic [IW-1:0] idx;
    logic [AW-1:0] rv, nv, mv, lowm, bufb, top, step, bw;
    logic [AW:0]   fw;
    logic          up, dn, lin;

    assign idx = IW'(g * PER) + IW'(u_sel[g]);
    assign rv  = r_q[idx];
    assign nv  = n_q[idx];
    assign mv  = m_q[idx];
    assign up  = (u_mode[g] == 3'd1) || (u_mode[g] == 3'd3);
    assign dn  = (u_mode[g] == 3'd2) || (u_mode[g] == 3'd4);
    assign lin = &mv;
    assign step = (u_mode[g] == 3'd3 || u_mode[g] == 3'd4) ? nv : AW'(1);

    always_comb begin
      lowm = mv;
      for (int j = 1; j < AW; j++) lowm = lowm | (mv >> j);
    end

    assign bufb = rv & ~lowm;
    assign top  = bufb + mv;
    assign fw   = {1'b0, rv} + {1'b0, step};
    assign bw   = rv - step;

    always_comb begin
      if (lin)
        u_next[g] = up ? fw[AW-1:0] : bw;
      else if (up)
        u_next[g] = (fw > {1'b0, top}) ? (fw[AW-1:0] - mv - AW'(1)) : fw[AW-1:0];
      else
        u_next[g] = ({1'b0, rv} < ({1'b0, bufb} + {1'b0, step})) ? (bw + mv + AW'(1)) : bw;
    end

    assign u_upd[g]  = u_en[g] && (up || dn);
    assign u_addr[g] = rv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q <= '0;
      n_q <= '0;
      m_q <= '1;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (rf_we && rf_wbank == 2'd0 && rf_wnum == IW'(i))
          r_q[i] <= rf_wdata;
        else if (u_upd[i / PER] && u_sel[i / PER] == SW'(i % PER))
          r_q[i] <= u_next[i / PER];
        if (rf_we && rf_wbank == 2'd1 && rf_wnum == IW'(i))
          n_q[i] <= rf_wdata;
        if (rf_we && rf_wbank == 2'd2 && rf_wnum == IW'(i))
          m_q[i] <= rf_wdata;
      end
    end
  end

  always_comb begin
    case (rf_rbank)
      2'd0:    rf_rdata = r_q[rf_rnum];
      2'd1:    rf_rdata = n_q[rf_rnum];
      2'd2:    rf_rdata = m_q[rf_rnum];
      default: rf_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_agu_chk.sv
module dual_agu_chk #(
  parameter int AW  = 10,
  parameter int PER = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         x_en,
  input logic [$clog2(PER)-1:0]       x_sel,
  input logic [2:0]                   x_mode,
  input logic                         y_en,
  input logic [$clog2(PER)-1:0]       y_sel,
  input logic [2:0]                   y_mode,
  input logic [AW-1:0]                x_addr,
  input logic [AW-1:0]                y_addr,
  input logic                         rf_we,
  input logic [1:0]                   rf_wbank,
  input logic [$clog2(2*PER)-1:0]     rf_wnum,
  input logic [AW-1:0]                rf_wdata,
  input logic [2*PER-1:0][AW-1:0]     r_q,
  input logic [2*PER-1:0][AW-1:0]     m_q
);
  localparam int IW = $clog2(2 * PER);

  function automatic logic [AW-1:0] fill(input logic [AW-1:0] v);
    logic [AW-1:0] o;
    o = v;
    for (int j = 1; j < AW; j++) o = o | (v >> j);
    return o;
  endfunction

  logic [IW-1:0] xi, yi;
  logic          x_wr_hit, y_wr_hit;
  assign xi = IW'(x_sel);
  assign yi = IW'(PER) + IW'(y_sel);
  assign x_wr_hit = rf_we && rf_wbank == 2'd0 && rf_wnum == xi;
  assign y_wr_hit = rf_we && rf_wbank == 2'd0 && rf_wnum == yi;

  p_linear_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && x_en && x_mode == 3'd1 && (&m_q[xi]) && !x_wr_hit)
    |-> r_q[$past(xi)] == $past(x_addr) + AW'(1));

  p_linear_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && y_en && y_mode == 3'd2 && (&m_q[yi]) && !y_wr_hit)
    |-> r_q[$past(yi)] == $past(y_addr) - AW'(1));

  p_mod_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && x_en && x_mode == 3'd1 && !(&m_q[xi]) && !x_wr_hit &&
          ((x_addr & fill(m_q[xi])) == m_q[xi]))
    |-> r_q[$past(xi)] == ($past(x_addr) & ~$past(fill(m_q[xi]))));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && rf_we && rf_wbank == 2'd0)
    |-> r_q[$past(rf_wnum)] == $past(rf_wdata));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && x_en && (x_mode == 3'd0 || x_mode > 3'd4) && !rf_we) &&
    x_sel == $past(x_sel)
    |-> x_addr == $past(x_addr));
endmodule

bind dual_agu dual_agu_chk #(.AW(AW), .PER(PER)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .x_en(x_en), .x_sel(x_sel), .x_mode(x_mode),
  .y_en(y_en), .y_sel(y_sel), .y_mode(y_mode),
  .x_addr(x_addr), .y_addr(y_addr),
  .rf_we(rf_we), .rf_wbank(rf_wbank), .rf_wnum(rf_wnum), .rf_wdata(rf_wdata),
  .r_q(r_q), .m_q(m_q)
);

// File: tb/test_dual_agu.sv
module test_dual_agu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_en = 0, y_en = 0, rf_we = 0;
  logic [1:0] x_sel = 0, y_sel = 0, rf_wbank = 0, rf_rbank = 0;
  logic [2:0] x_mode = 0, y_mode = 0, rf_wnum = 0, rf_rnum = 0;
  logic [9:0] rf_wdata = 0;
  logic [9:0] x_addr, y_addr, rf_rdata;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  dual_agu i_dual_agu (
    .clk(clk), .rst_n(rst_n),
    .x_en(x_en), .x_sel(x_sel), .x_mode(x_mode),
    .y_en(y_en), .y_sel(y_sel), .y_mode(y_mode),
    .x_addr(x_addr), .y_addr(y_addr),
    .rf_we(rf_we), .rf_wbank(rf_wbank), .rf_wnum(rf_wnum), .rf_wdata(rf_wdata),
    .rf_rbank(rf_rbank), .rf_rnum(rf_rnum), .rf_rdata(rf_rdata)
  );

  // {we,bank,num,wdata, xe,xsel,xmode, ye,ysel,ymode, chkx,expx, chky,expy}
  localparam int NV = 25;
  localparam logic [49:0] TBL [NV] = '{
    {1'b1,2'd0,3'd0,10'd100, 1'b0,2'd0,3'd0, 1'b0,2'd0,3'd0, 1'b0,10'd0,   1'b0,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd0,3'd1, 1'b1,2'd0,3'd1, 1'b1,10'd100, 1'b1,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd0,3'd1, 1'b1,2'd0,3'd2, 1'b1,10'd101, 1'b1,10'd1},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd0,3'd2, 1'b1,2'd0,3'd0, 1'b1,10'd102, 1'b1,10'd0},
    {1'b1,2'd1,3'd0,10'd7,   1'b1,2'd0,3'd0, 1'b1,2'd0,3'd2, 1'b1,10'd101, 1'b1,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd0,3'd3, 1'b1,2'd0,3'd0, 1'b1,10'd101, 1'b1,10'd1023},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd0,3'd4, 1'b1,2'd0,3'd1, 1'b1,10'd108, 1'b1,10'd1023},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd0,3'd5, 1'b1,2'd0,3'd0, 1'b1,10'd101, 1'b1,10'd0},
    {1'b1,2'd2,3'd1,10'd9,   1'b1,2'd0,3'd0, 1'b0,2'd0,3'd0, 1'b1,10'd101, 1'b0,10'd0},
    {1'b1,2'd0,3'd1,10'd37,  1'b0,2'd0,3'd0, 1'b0,2'd0,3'd0, 1'b0,10'd0,   1'b0,10'd0},
    {1'b1,2'd1,3'd1,10'd3,   1'b0,2'd0,3'd0, 1'b0,2'd0,3'd0, 1'b0,10'd0,   1'b0,10'd0},
    {1'b1,2'd2,3'd5,10'd7,   1'b0,2'd0,3'd0, 1'b0,2'd0,3'd0, 1'b0,10'd0,   1'b0,10'd0},
    {1'b1,2'd0,3'd5,10'd8,   1'b1,2'd1,3'd3, 1'b0,2'd0,3'd0, 1'b1,10'd37,  1'b0,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd1,3'd3, 1'b1,2'd1,3'd2, 1'b1,10'd40,  1'b1,10'd8},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd1,3'd4, 1'b1,2'd1,3'd1, 1'b1,10'd33,  1'b1,10'd15},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd1,3'd1, 1'b1,2'd1,3'd0, 1'b1,10'd40,  1'b1,10'd8},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd1,3'd1, 1'b0,2'd0,3'd0, 1'b1,10'd41,  1'b0,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd1,3'd2, 1'b0,2'd0,3'd0, 1'b1,10'd32,  1'b0,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd1,3'd0, 1'b0,2'd0,3'd0, 1'b1,10'd41,  1'b0,10'd0},
    {1'b1,2'd2,3'd2,10'd0,   1'b0,2'd0,3'd0, 1'b0,2'd0,3'd0, 1'b0,10'd0,   1'b0,10'd0},
    {1'b1,2'd0,3'd2,10'd500, 1'b0,2'd0,3'd0, 1'b0,2'd0,3'd0, 1'b0,10'd0,   1'b0,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd2,3'd1, 1'b0,2'd0,3'd0, 1'b1,10'd500, 1'b0,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd2,3'd2, 1'b0,2'd0,3'd0, 1'b1,10'd500, 1'b0,10'd0},
    {1'b1,2'd0,3'd3,10'd200, 1'b1,2'd3,3'd1, 1'b0,2'd0,3'd0, 1'b1,10'd0,   1'b0,10'd0},
    {1'b0,2'd0,3'd0,10'd0,   1'b1,2'd3,3'd0, 1'b0,2'd0,3'd0, 1'b1,10'd200, 1'b0,10'd0}
  };

  task automatic check(input string what, input logic [9:0] act, input logic [9:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] b, input logic [2:0] n, input logic [9:0] exp, input string what);
    rf_rbank = b;
    rf_rnum = n;
    #1;
    check(what, rf_rdata, exp);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, 3'd0, 10'd0,    "R1 pointer 0 after reset");
    rd(2'd1, 3'd3, 10'd0,    "R1 offset 3 after reset");
    rd(2'd2, 3'd7, 10'd1023, "R1 modifier 7 after reset");
    x_en = 1; x_sel = 2'd2; y_en = 1; y_sel = 2'd3;
    #1;
    check("R2 x_addr after reset", x_addr, 10'd0);
    check("R2 y_addr after reset", y_addr, 10'd0);

    // rows cover R2, R3 (row 8 mode 5), R4 (rows 2-8), R5 (rows 14-19),
    // R6 (rows 13-15), R7 (rows 22-23), R9 (rows 24-25)
    for (int k = 0; k < NV; k++) begin
      logic [49:0] v;
      v = TBL[k];
      @(negedge clk);
      rf_we = v[49]; rf_wbank = v[48:47]; rf_wnum = v[46:44]; rf_wdata = v[43:34];
      x_en = v[33]; x_sel = v[32:31]; x_mode = v[30:28];
      y_en = v[27]; y_sel = v[26:25]; y_mode = v[24:22];
      #1;
      if (v[21]) check($sformatf("R2 vector %0d x_addr", k + 1), x_addr, v[20:11]);
      if (v[10]) check($sformatf("R2 vector %0d y_addr", k + 1), y_addr, v[9:0]);
    end

    @(negedge clk);
    rf_we = 0; x_en = 0; y_en = 0;
    rd(2'd0, 3'd0, 10'd101,  "R4 pointer 0 after linear steps");
    rd(2'd0, 3'd4, 10'd0,    "R4 pointer 4 after wrap through 1023");
    rd(2'd0, 3'd1, 10'd41,   "R5 pointer 1 after circular steps");
    rd(2'd0, 3'd5, 10'd8,    "R6 pointer 5 after circular steps");
    rd(2'd0, 3'd2, 10'd500,  "R7 pointer 2 held by one-word buffer");
    rd(2'd0, 3'd3, 10'd200,  "R9 pointer 3 write beat increment");
    rd(2'd2, 3'd1, 10'd9,    "R8 modifier 1 readback");
    rd(2'd1, 3'd1, 10'd3,    "R8 offset 1 readback");

    rf_we = 1; rf_wbank = 2'd3; rf_wnum = 3'd0; rf_wdata = 10'd55;
    @(negedge clk);
    rf_we = 0;
    rd(2'd0, 3'd0, 10'd101,  "R8 bank 3 write left pointer 0");
    rd(2'd1, 3'd0, 10'd7,    "R8 bank 3 write left offset 0");
    rd(2'd2, 3'd0, 10'd1023, "R8 bank 3 write left modifier 0");
    rd(2'd3, 3'd0, 10'd0,    "R8 bank 3 read returns 0");

    x_en = 1; x_sel = 2'd0; x_mode = 3'd7;
    @(negedge clk);
    x_mode = 3'd0;
    #1;
    check("R3 mode 7 leaves pointer", x_addr, 10'd101);
    finish_run();
  end
endmodule